// File: doc/BRIEF.md
# Multi-size translation lookaside buffer

This block is a fully associative cache of virtual-to-physical mappings for a 32-bit address space. Every slot holds one mapping for a region of one of four sizes: 1 MiB, 64 KiB, 4 KiB or 1 KiB. Each slot compares only as many upper address bits as its own region size needs. A lookup gets its answer in the same cycle. A hit whose access rights allow the request returns the physical address. A hit whose rights forbid it raises an abort. A miss raises a walk request carrying the virtual address.

An external table walker answers a walk request by presenting a fill: the virtual and physical base bits, a size code and two permission bits. The fill is written into the slot named by a free-running pseudo-random pointer. A single-cycle flush empties the whole buffer.

A multi-word burst that runs across a region boundary is handled by the requester. It presents each address as its own lookup, and no lookup carries state into the next.

Top module: `region_tlb`

## Requirements
- R1: While reset is held, and after it, until the first fill, every lookup misses: `lk_hit` is low and `walk_req` is high whenever `req_valid` is high.
- R2: The size code selects which bits are compared against the stored virtual base. Code 0 compares bits 31:20, code 1 compares bits 31:16, code 2 compares bits 31:12 and code 3 compares bits 31:10.
- R3: On an allowed hit, `lk_pa` carries the stored physical base in the compared bits and the request's virtual address bits below them, unchanged.
- R4: `fill_perm[1]` grants user access and `fill_perm[0]` grants writes. A hit with `req_user` high and no user grant, or with `req_write` high and no write grant, drives `lk_abort` high, keeps `lk_hit` high and drives `lk_pa` to zero.
- R5: With `req_valid` high, exactly one of `lk_hit` and `walk_req` is high in the same cycle. While `walk_req` is high, `walk_va` equals `req_va`; otherwise `walk_va` is zero.
- R6: A fill written at a clock edge can be looked up from the next cycle onward.
- R7: A fill goes into the slot held by a 6-bit replacement register. The register is 0 after reset and advances on every clock: new = {old[4:0], old[5] ^ old[4] ^ (old[4:0] == 0)}. This visits all 64 slots in turn, and a fill overwrites whatever that slot held.
- R8: When several valid slots match one address, the slot with the lowest index supplies the result.
- R9: A flush empties every slot at the next edge. A fill presented in the same cycle as a flush is dropped, and the replacement register still advances.
- R10: While `req_valid` is low, `lk_hit`, `lk_abort` and `walk_req` are low and `lk_pa` is zero.
- R11: Consecutive lookups are independent. In a sequential run that crosses a region boundary, each address hits or misses on its own mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all slots at the next edge |
| req_valid | input | 1 | Lookup request present |
| req_va | input | 32 | Lookup virtual address |
| req_write | input | 1 | Lookup is a write |
| req_user | input | 1 | Lookup is from user mode |
| fill_valid | input | 1 | Fill present this cycle |
| fill_vtag | input | 22 | Virtual address bits 31:10 of the new mapping |
| fill_ptag | input | 22 | Physical address bits 31:10 of the new mapping |
| fill_size | input | 2 | Region size code (0: 1 MiB, 1: 64 KiB, 2: 4 KiB, 3: 1 KiB) |
| fill_perm | input | 2 | Bit 1 user allowed, bit 0 write allowed |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_abort | output | 1 | Matched slot forbids this access |
| lk_pa | output | 32 | Translated physical address (zero unless an allowed hit) |
| walk_req | output | 1 | Lookup missed; table walk needed |
| walk_va | output | 32 | Virtual address to walk (zero unless `walk_req`) |

## Verification
A slot that holds the wrong tag, size or permission shows on the same cycle as a lookup of that address. It can appear as a hit where a walk was due, as a wrong physical address or as a missing abort. A replacement pointer that drifts from its sequence stays hidden until a fill lands on a slot the bench did not expect. The damage then shows either when the mapping that should have survived is looked up and misses, or when two overlapping mappings resolve in the wrong priority order. The bench therefore fills past one full turn of the pointer and then looks up every address it filled.

// File: rtl/region_tlb_pkg.sv
package region_tlb_pkg;

   // Region size codes; the numeric order is the order of shrinking size.
   typedef enum logic [1:0] {
      SZ_SECTION = 2'd0,
      SZ_LARGE   = 2'd1,
      SZ_SMALL   = 2'd2,
      SZ_TINY    = 2'd3
   } rsize_e;

   // Access rights carried by each slot.
   typedef struct packed {
      logic user_ok;
      logic write_ok;
   } perm_t;

   // Replacement pointer variants.
   typedef enum logic {
      REPL_LFSR  = 1'b0,
      REPL_COUNT = 1'b1
   } repl_e;

   // Feedback taps (shift-left form) for maximal sequences of width 2..8.
   function automatic int unsigned lfsr_taps(input int unsigned w);
      case (w)
         2:       return 'h3;
         3:       return 'h6;
         4:       return 'hC;
         5:       return 'h14;
         6:       return 'h30;
         7:       return 'h60;
         8:       return 'hB8;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/rtlb_victim.sv
module rtlb_victim
   import region_tlb_pkg::*;
#(
   parameter int unsigned IDX_W = 6,
   parameter repl_e       MODE  = REPL_LFSR
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [IDX_W-1:0] idx
);

   logic [IDX_W-1:0] nxt;

   generate
      if (MODE == REPL_LFSR) begin : g_lfsr
         localparam logic [IDX_W-1:0] TAPS = IDX_W'(lfsr_taps(IDX_W));
         logic fb;
         // The zero-detect term splices the all-zero state into the cycle,
         // so every slot index is produced once per turn.
         always_comb begin
            fb  = (^(idx & TAPS)) ^ (idx[IDX_W-2:0] == '0);
            nxt = {idx[IDX_W-2:0], fb};
         end
      end else begin : g_count
         always_comb nxt = idx + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx <= '0;
      else        idx <= nxt;
   end

endmodule

// File: rtl/rtlb_slot.sv
module rtlb_slot
   import region_tlb_pkg::*;
#(
   parameter int unsigned VA_W    = 32,
   parameter int unsigned OFF_SEC = 20,
   parameter int unsigned OFF_LRG = 16,
   parameter int unsigned OFF_SML = 12,
   parameter int unsigned OFF_TNY = 10,
   localparam int unsigned TAG_W  = VA_W - OFF_TNY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_vtag,
   input  logic [TAG_W-1:0] wr_ptag,
   input  rsize_e           wr_size,
   input  perm_t            wr_perm,
   input  logic [VA_W-1:0]  lk_va,
   output logic             match,
   output logic [VA_W-1:0]  cand_pa,
   output perm_t            perm
);

   logic             vld;
   logic [TAG_W-1:0] vtag;
   logic [TAG_W-1:0] ptag;
   rsize_e           sz;
   logic [VA_W-1:0]  amask;

   // Valid bit: flush dominates a write in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld <= 1'b0;
      else if (flush) vld <= 1'b0;
      else if (wr_en) vld <= 1'b1;
   end

   // Payload needs no reset; it is qualified by the valid bit.
   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         vtag <= wr_vtag;
         ptag <= wr_ptag;
         sz   <= wr_size;
         perm <= wr_perm;
      end
   end

   // Compare mask chosen per slot by its own region size.
   always_comb begin
      case (sz)
         SZ_SECTION: amask = {VA_W{1'b1}} << OFF_SEC;
         SZ_LARGE:   amask = {VA_W{1'b1}} << OFF_LRG;
         SZ_SMALL:   amask = {VA_W{1'b1}} << OFF_SML;
         default:    amask = {VA_W{1'b1}} << OFF_TNY;
      endcase
   end

   always_comb begin
      match   = vld && (((lk_va ^ {vtag, {OFF_TNY{1'b0}}}) & amask) == '0);
      cand_pa = ({ptag, {OFF_TNY{1'b0}}} & amask) | (lk_va & ~amask);
   end

endmodule

// File: rtl/rtlb_pick.sv
module rtlb_pick #(
   parameter int unsigned N = 64
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);

   // Isolate the lowest set bit: the lowest index wins.
   always_comb begin
      grant = req & (~req + 1'b1);
      any   = |req;
   end

endmodule

// File: rtl/region_tlb.sv
module region_tlb
   import region_tlb_pkg::*;
#(
   parameter int unsigned VA_W    = 32,
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned OFF_SEC = 20,
   parameter int unsigned OFF_LRG = 16,
   parameter int unsigned OFF_SML = 12,
   parameter int unsigned OFF_TNY = 10,
   parameter repl_e       REPL    = REPL_LFSR,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned TAG_W  = VA_W - OFF_TNY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_va,
   input  logic             req_write,
   input  logic             req_user,
   input  logic             fill_valid,
   input  logic [TAG_W-1:0] fill_vtag,
   input  logic [TAG_W-1:0] fill_ptag,
   input  logic [1:0]       fill_size,
   input  logic [1:0]       fill_perm,
   output logic             lk_hit,
   output logic             lk_abort,
   output logic [VA_W-1:0]  lk_pa,
   output logic             walk_req,
   output logic [VA_W-1:0]  walk_va
);

   // Elaboration-time parameter checks.
   generate
      if (!(OFF_TNY >= 1 && OFF_TNY < OFF_SML && OFF_SML < OFF_LRG &&
            OFF_LRG < OFF_SEC && OFF_SEC < VA_W)) begin : g_bad_offsets
         $error("region_tlb: region offsets must rise strictly below VA_W");
      end
      if ((1 << IDX_W) != ENTRIES) begin : g_bad_entries
         $error("region_tlb: ENTRIES must be a power of two");
      end
      if (REPL == REPL_LFSR && (IDX_W < 2 || IDX_W > 8)) begin : g_bad_lfsr
         $error("region_tlb: LFSR replacement needs 4 to 256 entries");
      end
   endgenerate

   logic [IDX_W-1:0]   victim_idx;
   logic [ENTRIES-1:0] match;
   logic [ENTRIES-1:0] grant;
   logic               any_match;
   logic [VA_W-1:0]    cand_pa [ENTRIES];
   perm_t              slot_perm [ENTRIES];
   logic [VA_W-1:0]    sel_pa;
   perm_t              sel_perm;
   logic               deny;
   logic               hit;

   rtlb_victim #(
      .IDX_W (IDX_W),
      .MODE  (REPL)
   ) i_victim (
      .clk   (clk),
      .rst_n (rst_n),
      .idx   (victim_idx)
   );

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
         rtlb_slot #(
            .VA_W    (VA_W),
            .OFF_SEC (OFF_SEC),
            .OFF_LRG (OFF_LRG),
            .OFF_SML (OFF_SML),
            .OFF_TNY (OFF_TNY)
         ) i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .wr_en   (fill_valid && (victim_idx == IDX_W'(g))),
            .wr_vtag (fill_vtag),
            .wr_ptag (fill_ptag),
            .wr_size (rsize_e'(fill_size)),
            .wr_perm (perm_t'(fill_perm)),
            .lk_va   (req_va),
            .match   (match[g]),
            .cand_pa (cand_pa[g]),
            .perm    (slot_perm[g])
         );
      end
   endgenerate

   rtlb_pick #(
      .N     (ENTRIES)
   ) i_pick (
      .req   (match),
      .grant (grant),
      .any   (any_match)
   );

   // One-hot AND-OR selection of the winning slot.
   always_comb begin
      sel_pa   = '0;
      sel_perm = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         sel_pa   = sel_pa   | (cand_pa[i] & {VA_W{grant[i]}});
         sel_perm = sel_perm | (slot_perm[i] & {2{grant[i]}});
      end
   end

   always_comb begin
      hit      = req_valid && any_match;
      deny     = (req_user && !sel_perm.user_ok) || (req_write && !sel_perm.write_ok);
      lk_hit   = hit;
      lk_abort = hit && deny;
      lk_pa    = (hit && !deny) ? sel_pa : '0;
      walk_req = req_valid && !any_match;
      walk_va  = walk_req ? req_va : '0;
   end

endmodule

// File: rtl/region_tlb_chk.sv
module region_tlb_chk #(
   parameter int unsigned VA_W    = 32,
   parameter int unsigned OFF_TNY = 10,
   parameter int unsigned IDX_W   = 6,
   localparam int unsigned TAG_W  = VA_W - OFF_TNY
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             req_valid,
   input logic [VA_W-1:0]  req_va,
   input logic             fill_valid,
   input logic [TAG_W-1:0] fill_vtag,
   input logic             lk_hit,
   input logic             lk_abort,
   input logic [VA_W-1:0]  lk_pa,
   input logic             walk_req,
   input logic [VA_W-1:0]  walk_va,
   input logic [IDX_W-1:0] victim_idx
);

   // R3: offset bits below the smallest region pass through untouched
   a_r3_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && !lk_abort) |-> (lk_pa[OFF_TNY-1:0] == req_va[OFF_TNY-1:0]));

   // R4: an abort only accompanies a hit and suppresses the address
   a_r4_abort_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      lk_abort |-> (lk_hit && lk_pa == '0));

   // R5: a valid request either hits or asks for a walk, never both
   a_r5_hit_xor_walk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (lk_hit != walk_req));

   // R5: the walk carries the requested address
   a_r5_walk_addr: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> (walk_va == req_va));

   // R6: a fill is visible on the following cycle
   a_r6_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !flush) |=>
      (!(req_valid && req_va[VA_W-1:OFF_TNY] == $past(fill_vtag)) || lk_hit));

   // R7: the replacement pointer moves on every clock
   a_r7_victim_moves: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (victim_idx != $past(victim_idx)));

   // R9: nothing hits right after a flush
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit);

   // R10: idle requests leave every output quiet
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!lk_hit && !lk_abort && !walk_req && lk_pa == '0 && walk_va == '0));

endmodule

bind region_tlb region_tlb_chk #(
   .VA_W    (VA_W),
   .OFF_TNY (OFF_TNY),
   .IDX_W   (IDX_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .req_valid  (req_valid),
   .req_va     (req_va),
   .fill_valid (fill_valid),
   .fill_vtag  (fill_vtag),
   .lk_hit     (lk_hit),
   .lk_abort   (lk_abort),
   .lk_pa      (lk_pa),
   .walk_req   (walk_req),
   .walk_va    (walk_va),
   .victim_idx (victim_idx)
);

// File: tb/test_region_tlb.sv
module test_region_tlb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        fill_valid = 1'b0;
   logic [21:0] fill_vtag = '0;
   logic [21:0] fill_ptag = '0;
   logic [1:0]  fill_size = '0;
   logic [1:0]  fill_perm = '0;
   logic        lk_hit;
   logic        lk_abort;
   logic [31:0] lk_pa;
   logic        walk_req;
   logic [31:0] walk_va;

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;
   string cur_req = "R1";

   // Behavioural reference state.
   bit          m_vld  [64];
   logic [31:0] m_va   [64];
   logic [31:0] m_pa   [64];
   logic [1:0]  m_sz   [64];
   logic [1:0]  m_pm   [64];
   int          m_vic = 0;

   always #5 clk = ~clk;

   region_tlb i_region_tlb (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .req_valid  (req_valid),
      .req_va     (req_va),
      .req_write  (req_write),
      .req_user   (req_user),
      .fill_valid (fill_valid),
      .fill_vtag  (fill_vtag),
      .fill_ptag  (fill_ptag),
      .fill_size  (fill_size),
      .fill_perm  (fill_perm),
      .lk_hit     (lk_hit),
      .lk_abort   (lk_abort),
      .lk_pa      (lk_pa),
      .walk_req   (walk_req),
      .walk_va    (walk_va)
   );

   // R2: size code to compared-bit mask
   function automatic logic [31:0] size_mask(input logic [1:0] s);
      case (s)
         2'd0:    return 32'hFFF0_0000;
         2'd1:    return 32'hFFFF_0000;
         2'd2:    return 32'hFFFF_F000;
         default: return 32'hFFFF_FC00;
      endcase
   endfunction

   // R7: replacement sequence
   function automatic int vic_next(input int v);
      int fb;
      fb = ((v >> 5) ^ (v >> 4)) & 1;
      if ((v & 31) == 0) fb = fb ^ 1;
      return ((v << 1) & 63) | fb;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
         m_vic = 0;
      end else begin
         if (flush) begin
            for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
         end else if (fill_valid) begin
            m_vld[m_vic] = 1'b1;
            m_va[m_vic]  = {fill_vtag, 10'h0};
            m_pa[m_vic]  = {fill_ptag, 10'h0};
            m_sz[m_vic]  = fill_size;
            m_pm[m_vic]  = fill_perm;
         end
         m_vic = vic_next(m_vic);
      end
   end

   // Compare every cycle, mid-period.
   always @(negedge clk) begin
      logic        e_hit, e_abort, e_walk;
      logic [31:0] e_pa, e_wva, mk;
      int          w;
      if (!done) begin
         e_hit = 1'b0; e_abort = 1'b0; e_walk = 1'b0; e_pa = '0; e_wva = '0;
         if (req_valid) begin
            w = -1;
            for (int i = 63; i >= 0; i--) begin
               mk = size_mask(m_sz[i]);
               if (m_vld[i] && ((req_va & mk) == (m_va[i] & mk))) w = i;
            end
            if (w < 0) begin
               e_walk = 1'b1;
               e_wva  = req_va;
            end else begin
               e_hit = 1'b1;
               mk    = size_mask(m_sz[w]);
               if ((req_user && !m_pm[w][1]) || (req_write && !m_pm[w][0]))
                  e_abort = 1'b1;
               else
                  e_pa = (m_pa[w] & mk) | (req_va & ~mk);
            end
         end
         n_chk++;
         if (lk_hit !== e_hit || lk_abort !== e_abort || lk_pa !== e_pa ||
             walk_req !== e_walk || walk_va !== e_wva) begin
            n_fail++;
            $display("FAIL %s va=%h: got hit=%b abort=%b pa=%h walk=%b wva=%h exp hit=%b abort=%b pa=%h walk=%b wva=%h",
                     cur_req, req_va, lk_hit, lk_abort, lk_pa, walk_req, walk_va,
                     e_hit, e_abort, e_pa, e_walk, e_wva);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic look(input logic [31:0] va, input logic wr, input logic usr);
      req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
      step();
      req_valid = 1'b0; req_write = 1'b0; req_user = 1'b0;
   endtask

   task automatic fill(input logic [31:0] va, input logic [31:0] pa,
                       input logic [1:0] sz, input logic [1:0] pm);
      fill_valid = 1'b1; fill_vtag = va[31:10]; fill_ptag = pa[31:10];
      fill_size = sz; fill_perm = pm;
      step();
      fill_valid = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got no completion exp completion");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b1;
      #1 rst_n = 1'b0;
      // R1: lookups during reset miss
      cur_req = "R1";
      req_valid = 1'b1; req_va = 32'h1234_5678;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      req_valid = 1'b0;
      look(32'h0000_0000, 1'b0, 1'b0);
      look(32'hFFFF_FFFC, 1'b1, 1'b1);

      // R2 R3: section mapping, edges of the 1 MiB window
      cur_req = "R2";
      fill(32'h1230_0000, 32'h8AB0_0000, 2'd0, 2'b11);
      cur_req = "R3";
      look(32'h123F_FFFC, 1'b0, 1'b0);
      look(32'h1230_0004, 1'b1, 1'b1);
      cur_req = "R2";
      look(32'h1240_0000, 1'b0, 1'b0);
      look(32'h122F_FFFC, 1'b0, 1'b0);

      // R4: large page read-only, user allowed
      cur_req = "R4";
      fill(32'h4567_0000, 32'h0011_0000, 2'd1, 2'b10);
      look(32'h4567_ABCC, 1'b0, 1'b1);
      look(32'h4567_ABCC, 1'b1, 1'b1);
      look(32'h4567_0000, 1'b1, 1'b0);
      // R4: small page supervisor only, writable
      fill(32'h0000_5000, 32'hC000_A000, 2'd2, 2'b01);
      look(32'h0000_5123, 1'b0, 1'b1);
      look(32'h0000_5123, 1'b1, 1'b0);
      cur_req = "R2";
      look(32'h0000_6000, 1'b0, 1'b0);

      // R2 R3: tiny page
      fill(32'h0000_7C00, 32'h0FF0_0400, 2'd3, 2'b11);
      cur_req = "R3";
      look(32'h0000_7FFC, 1'b1, 1'b1);

      // R11: sequential run crossing region boundaries
      cur_req = "R11";
      req_valid = 1'b1; req_write = 1'b0; req_user = 1'b0;
      for (int k = 0; k < 4; k++) begin
         req_va = 32'h0000_7FF8 + 32'(k * 4);
         step();
      end
      for (int k = 0; k < 4; k++) begin
         req_va = 32'h0000_5FF8 + 32'(k * 4);
         step();
      end
      req_valid = 1'b0;

      // R5: misses carry the address out
      cur_req = "R5";
      look(32'hDEAD_BEEC, 1'b1, 1'b0);
      look(32'h1230_0010, 1'b0, 1'b0);

      // R10: idle with a matching address on the bus
      cur_req = "R10";
      req_va = 32'h123F_0000; req_write = 1'b1; req_user = 1'b1;
      step();
      step();
      req_write = 1'b0; req_user = 1'b0;

      // R8: overlapping section covering the tiny and small pages
      cur_req = "R8";
      fill(32'h0000_0000, 32'h7700_0000, 2'd0, 2'b11);
      look(32'h0000_7C40, 1'b0, 1'b0);
      look(32'h0000_5004, 1'b0, 1'b1);
      look(32'h0000_9000, 1'b0, 1'b1);

      // R6: fill followed at once by lookup
      cur_req = "R6";
      fill(32'h3000_0000, 32'h5000_0000, 2'd2, 2'b11);
      look(32'h3000_0FFC, 1'b1, 1'b1);

      // R9: flush with a simultaneous fill
      cur_req = "R9";
      flush = 1'b1;
      fill(32'h6000_0000, 32'h6100_0000, 2'd0, 2'b11);
      flush = 1'b0;
      look(32'h6000_0000, 1'b0, 1'b0);
      look(32'h1230_0000, 1'b0, 1'b0);
      look(32'h3000_0000, 1'b0, 1'b0);
      fill(32'h6000_0000, 32'h6100_0000, 2'd0, 2'b11);
      look(32'h600F_0000, 1'b0, 1'b0);

      // R7: fill past one full turn, then look everything up
      cur_req = "R7";
      for (int k = 0; k < 70; k++) begin
         fill_valid = 1'b1;
         fill_vtag  = 22'(32'h0100_0000 + 32'(k * 32'h400) >> 10);
         fill_ptag  = 22'(32'h2000_0000 + 32'(k * 32'h400) >> 10);
         fill_size  = 2'd3;
         fill_perm  = 2'(k % 4);
         step();
      end
      fill_valid = 1'b0;
      for (int k = 0; k < 70; k++) begin
         look(32'h0100_0000 + 32'(k * 32'h400) + 32'h3C, 1'(k % 2), 1'(k % 3 == 0));
      end
      look(32'h600F_0000, 1'b0, 1'b0);

      step();
      finish_run();
   end

endmodule